// File: doc/BRIEF.md
# Quadrant-Banked Register File with Shared Crossbar

This block holds a register file that is split into four independent storage quadrants. Each quadrant sits beside its own function-unit group and serves that group through private read and write ports. Consecutive register numbers land in different quadrants, so four groups working on four neighbouring registers never compete for a port and all run in the same cycle.

When a group names a register that lives in another quadrant, the access goes over one shared 4x4 crossbar. Every lane of the crossbar is one data word wide (32 bits by default). Each destination quadrant takes at most one crossbar transfer per cycle, either a read or a write. A rotating-priority arbiter for each destination picks that transfer. Every requester that loses sees its stall output high and keeps its request until it is served. Reads on either path return registered data one cycle after they are served. Writes on either path commit at the clock edge that ends the cycle in which they are served.

Top module: `qbank_regfile`

## Requirements
- R1: A register address splits into a quadrant number, taken from the two least significant address bits, and an in-quadrant index, taken from the remaining upper bits. Group g owns quadrant g.
- R2: A read or write from group g to a register in quadrant g never stalls. Read data appears on that port one cycle later, with rd_vld high.
- R3: All four groups can each use every local read port and their local write port in the same cycle with no stall on any port.
- R4: A non-local access goes over the crossbar. Each destination quadrant serves at most one crossbar access per cycle. Every other non-local request to that quadrant has its stall output high that cycle. A stall output is never high without its enable.
- R5: Requesters are numbered id = group*(NRD+1) + port, where ports 0..NRD-1 are reads and port NRD is the write. For each destination, the search starts at a pointer that is 0 after reset and takes the lowest id at or cyclically above the pointer. After a grant to id k, the pointer becomes k+1, wrapping to 0. A request held toward one quadrant waits fewer than NG*(NRD+1) cycles.
- R6: Data for a granted crossbar read appears on the requesting port one cycle after the grant cycle, with rd_vld high.
- R7: A granted crossbar write commits at the end of its grant cycle. A read of that register served in the next cycle returns the new value.
- R8: If a local write and a crossbar write target the same register in the same cycle, the local write's data is stored.
- R9: A read served in the same cycle as a write to the same register returns the value held before that write.
- R10: rd_vld is high in a cycle exactly when that port was enabled and not stalled in the previous cycle. While rd_vld is low, rd_data keeps its previous value.
- R11: Synchronous active-high reset clears every register to zero and every rd_vld and rd_data to zero, and sets every arbitration pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | NG*NRD | Read enable, port p of group g at bit g*NRD+p |
| rd_addr | input | NG*NRD*AW | Read register address per port |
| rd_stall | output | NG*NRD | Read request lost crossbar arbitration this cycle |
| rd_vld | output | NG*NRD | Read data valid (one cycle after service) |
| rd_data | output | NG*NRD*DW | Read data per port |
| wr_en | input | NG | Write enable per group |
| wr_addr | input | NG*AW | Write register address per group |
| wr_data | input | NG*DW | Write data per group |
| wr_stall | output | NG | Write request lost crossbar arbitration this cycle |

## Verification
Two services can collide in one cycle. A quadrant's own write port and a crossbar write from another group can target the same register. A quadrant can also be read and written at the same register in the same cycle, on either path. The bench provokes both collisions with directed cycles and then with a long random run over a small address space, which makes such overlaps frequent. A reference model applies crossbar writes before local writes and takes read values before any write. Every returned word and every stall bit is compared against that model.

// File: rtl/qbr_pkg.sv
package qbr_pkg;

    // quadrant count is structural: the address split depends on it
    localparam int NQ     = 4;
    localparam int QSEL_W = 2;

    // how a read port is served in a given cycle
    typedef enum logic [1:0] {
        PATH_IDLE  = 2'd0,
        PATH_LOCAL = 2'd1,
        PATH_XBAR  = 2'd2
    } path_t;

    typedef struct packed {
        path_t              path;
        logic [QSEL_W-1:0]  src_q;
    } rd_route_t;

    // cyclic successor in a ring of n entries
    function automatic int ring_next(input int cur, input int n);
        return (cur >= n - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/qbr_rr_arb.sv
module qbr_rr_arb #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    import qbr_pkg::*;

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;
    logic          found;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < N; i++) begin
            int j;
            j = int'(ptr) + i;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                found  = 1'b1;
                gnt[j] = 1'b1;
                win    = IW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (found) begin
            ptr <= IW'(ring_next(int'(win), N));
        end
    end

endmodule

// File: rtl/qbr_bank.sv
module qbr_bank #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int NRD   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NRD*IW-1:0] lrd_idx,
    output logic [NRD*DW-1:0] lrd_data,
    input  logic [IW-1:0]     xrd_idx,
    output logic [DW-1:0]     xrd_data,
    input  logic              lwr_en,
    input  logic [IW-1:0]     lwr_idx,
    input  logic [DW-1:0]     lwr_data,
    input  logic              xwr_en,
    input  logic [IW-1:0]     xwr_idx,
    input  logic [DW-1:0]     xwr_data
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];

    // reads see the contents before this cycle's writes
    for (genvar p = 0; p < NRD; p++) begin : g_lrd
        assign lrd_data[p*DW +: DW] = mem[lrd_idx[p*IW +: IW]];
    end
    assign xrd_data = mem[xrd_idx];

    // crossbar write first, local write last so it wins a same-index clash
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else begin
            if (xwr_en) mem[xwr_idx] <= xwr_data;
            if (lwr_en) mem[lwr_idx] <= lwr_data;
        end
    end

endmodule

// File: rtl/qbr_xbar.sv
module qbr_xbar #(
    parameter int NREQ = 16,
    parameter int IW   = 3,
    parameter int DW   = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NREQ-1:0]               req_vld,
    input  logic [NREQ-1:0]               req_wr,
    input  logic [NREQ*qbr_pkg::QSEL_W-1:0] req_dst,
    input  logic [NREQ*IW-1:0]            req_idx,
    input  logic [NREQ*DW-1:0]            req_data,
    output logic [NREQ-1:0]               gnt,
    output logic [qbr_pkg::NQ-1:0]        x_rd_en,
    output logic [qbr_pkg::NQ*IW-1:0]     x_rd_idx,
    output logic [qbr_pkg::NQ-1:0]        x_wr_en,
    output logic [qbr_pkg::NQ*IW-1:0]     x_wr_idx,
    output logic [qbr_pkg::NQ*DW-1:0]     x_wr_data
);
    import qbr_pkg::*;

    logic [NREQ-1:0] dreq  [NQ];
    logic [NREQ-1:0] dgnt  [NQ];

    for (genvar d = 0; d < NQ; d++) begin : g_dst
        for (genvar i = 0; i < NREQ; i++) begin : g_rq
            assign dreq[d][i] = req_vld[i] &&
                                (req_dst[i*QSEL_W +: QSEL_W] == QSEL_W'(d));
        end

        qbr_rr_arb #(.N(NREQ)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (dreq[d]),
            .gnt (dgnt[d])
        );

        // route the single winner of this destination onto its lane
        always_comb begin
            x_rd_en[d]               = 1'b0;
            x_wr_en[d]               = 1'b0;
            x_rd_idx[d*IW +: IW]     = '0;
            x_wr_idx[d*IW +: IW]     = '0;
            x_wr_data[d*DW +: DW]    = '0;
            for (int i = 0; i < NREQ; i++) begin
                if (dgnt[d][i]) begin
                    if (req_wr[i]) begin
                        x_wr_en[d]            = 1'b1;
                        x_wr_idx[d*IW +: IW]  = req_idx[i*IW +: IW];
                        x_wr_data[d*DW +: DW] = req_data[i*DW +: DW];
                    end else begin
                        x_rd_en[d]            = 1'b1;
                        x_rd_idx[d*IW +: IW]  = req_idx[i*IW +: IW];
                    end
                end
            end
        end
    end

    always_comb begin
        gnt = '0;
        for (int d = 0; d < NQ; d++) gnt = gnt | dgnt[d];
    end

endmodule

// File: rtl/qbank_regfile.sv
module qbank_regfile #(
    parameter int DW     = 32,
    parameter int QDEPTH = 8,
    parameter int NRD    = 3,
    localparam int NG    = qbr_pkg::NQ,
    localparam int IW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
    localparam int AW    = qbr_pkg::QSEL_W + IW,
    localparam int NRP   = NG * NRD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NRP-1:0]    rd_en,
    input  logic [NRP*AW-1:0] rd_addr,
    output logic [NRP-1:0]    rd_stall,
    output logic [NRP-1:0]    rd_vld,
    output logic [NRP*DW-1:0] rd_data,
    input  logic [NG-1:0]     wr_en,
    input  logic [NG*AW-1:0]  wr_addr,
    input  logic [NG*DW-1:0]  wr_data,
    output logic [NG-1:0]     wr_stall
);
    import qbr_pkg::*;

    localparam int NPORT = NRD + 1;
    localparam int NREQ  = NG * NPORT;

    // crossbar request side
    logic [NREQ-1:0]        req_vld;
    logic [NREQ-1:0]        req_wr;
    logic [NREQ*QSEL_W-1:0] req_dst;
    logic [NREQ*IW-1:0]     req_idx;
    logic [NREQ*DW-1:0]     req_data;
    logic [NREQ-1:0]        gnt;

    // crossbar lane side, one lane per destination quadrant
    logic [NG-1:0]          x_rd_en;
    logic [NG*IW-1:0]       x_rd_idx;
    logic [NG-1:0]          x_wr_en;
    logic [NG*IW-1:0]       x_wr_idx;
    logic [NG*DW-1:0]       x_wr_data;

    // bank side
    logic [NRP*IW-1:0]      lrd_idx_all;
    logic [NRP*DW-1:0]      lrd_data_all;
    logic [NG*DW-1:0]       xrd_data_all;
    logic [NG-1:0]          lwr_en;
    logic [NG*IW-1:0]       lwr_idx;

    // read ports: decode, request, stall and registered return
    for (genvar g = 0; g < NG; g++) begin : g_grp
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            localparam int RI = g * NRD + p;
            localparam int ID = g * NPORT + p;

            logic [AW-1:0]     addr;
            logic [QSEL_W-1:0] q;
            logic [IW-1:0]     idx;
            logic              loc;
            rd_route_t         rt;
            logic              vld_r;
            logic [DW-1:0]     dat_r;

            assign addr = rd_addr[RI*AW +: AW];
            assign q    = addr[QSEL_W-1:0];
            assign idx  = addr[AW-1:QSEL_W];
            assign loc  = (q == QSEL_W'(g));

            assign req_vld[ID]                    = rd_en[RI] & ~loc;
            assign req_wr[ID]                     = 1'b0;
            assign req_dst[ID*QSEL_W +: QSEL_W]   = q;
            assign req_idx[ID*IW +: IW]           = idx;
            assign req_data[ID*DW +: DW]          = '0;
            assign lrd_idx_all[RI*IW +: IW]       = idx;

            assign rd_stall[RI] = rd_en[RI] & ~loc & ~gnt[ID];

            always_comb begin
                rt.src_q = q;
                if (!rd_en[RI])   rt.path = PATH_IDLE;
                else if (loc)     rt.path = PATH_LOCAL;
                else if (gnt[ID]) rt.path = PATH_XBAR;
                else              rt.path = PATH_IDLE;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_r <= 1'b0;
                    dat_r <= '0;
                end else begin
                    vld_r <= (rt.path != PATH_IDLE);
                    case (rt.path)
                        PATH_LOCAL: dat_r <= lrd_data_all[RI*DW +: DW];
                        PATH_XBAR:  dat_r <= xrd_data_all[rt.src_q*DW +: DW];
                        default:    dat_r <= dat_r;
                    endcase
                end
            end

            assign rd_vld[RI]            = vld_r;
            assign rd_data[RI*DW +: DW]  = dat_r;
        end

        // write port of group g
        begin : g_wr
            localparam int ID = g * NPORT + NRD;

            logic [AW-1:0]     addr;
            logic [QSEL_W-1:0] q;
            logic              loc;

            assign addr = wr_addr[g*AW +: AW];
            assign q    = addr[QSEL_W-1:0];
            assign loc  = (q == QSEL_W'(g));

            assign req_vld[ID]                  = wr_en[g] & ~loc;
            assign req_wr[ID]                   = 1'b1;
            assign req_dst[ID*QSEL_W +: QSEL_W] = q;
            assign req_idx[ID*IW +: IW]         = addr[AW-1:QSEL_W];
            assign req_data[ID*DW +: DW]        = wr_data[g*DW +: DW];

            assign lwr_en[g]            = wr_en[g] & loc;
            assign lwr_idx[g*IW +: IW]  = addr[AW-1:QSEL_W];
            assign wr_stall[g]          = wr_en[g] & ~loc & ~gnt[ID];
        end

        qbr_bank #(.DW(DW), .DEPTH(QDEPTH), .NRD(NRD)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .lrd_idx  (lrd_idx_all[g*NRD*IW +: NRD*IW]),
            .lrd_data (lrd_data_all[g*NRD*DW +: NRD*DW]),
            .xrd_idx  (x_rd_idx[g*IW +: IW]),
            .xrd_data (xrd_data_all[g*DW +: DW]),
            .lwr_en   (lwr_en[g]),
            .lwr_idx  (lwr_idx[g*IW +: IW]),
            .lwr_data (wr_data[g*DW +: DW]),
            .xwr_en   (x_wr_en[g]),
            .xwr_idx  (x_wr_idx[g*IW +: IW]),
            .xwr_data (x_wr_data[g*DW +: DW])
        );
    end

    qbr_xbar #(.NREQ(NREQ), .IW(IW), .DW(DW)) u_xbar (
        .clk       (clk),
        .rst       (rst),
        .req_vld   (req_vld),
        .req_wr    (req_wr),
        .req_dst   (req_dst),
        .req_idx   (req_idx),
        .req_data  (req_data),
        .gnt       (gnt),
        .x_rd_en   (x_rd_en),
        .x_rd_idx  (x_rd_idx),
        .x_wr_en   (x_wr_en),
        .x_wr_idx  (x_wr_idx),
        .x_wr_data (x_wr_data)
    );

    // a read lane whose winner is a write carries no read; keep it observed
    logic unused_rd_en;
    assign unused_rd_en = ^x_rd_en;

endmodule

// File: rtl/qbr_checker.sv
module qbr_checker #(
    parameter int DW     = 32,
    parameter int QDEPTH = 8,
    parameter int NRD    = 3,
    localparam int NG    = qbr_pkg::NQ,
    localparam int IW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
    localparam int AW    = qbr_pkg::QSEL_W + IW,
    localparam int NRP   = NG * NRD
) (
    input logic              clk,
    input logic              rst,
    input logic [NRP-1:0]    rd_en,
    input logic [NRP*AW-1:0] rd_addr,
    input logic [NRP-1:0]    rd_stall,
    input logic [NRP-1:0]    rd_vld,
    input logic [NRP*DW-1:0] rd_data,
    input logic [NG-1:0]     wr_en,
    input logic [NG*AW-1:0]  wr_addr,
    input logic [NG*DW-1:0]  wr_data,
    input logic [NG-1:0]     wr_stall
);
    import qbr_pkg::*;

    localparam int NREQ = NG * (NRD + 1);
    localparam int CW   = $clog2(NREQ + 1) + 1;

    // served non-local accesses per destination, computed from ports only
    logic [NREQ-1:0] served [NG];

    always_comb begin
        for (int d = 0; d < NG; d++) begin
            served[d] = '0;
            for (int g = 0; g < NG; g++) begin
                for (int p = 0; p < NRD; p++) begin
                    if (rd_en[g*NRD+p] && !rd_stall[g*NRD+p] &&
                        rd_addr[(g*NRD+p)*AW +: QSEL_W] != QSEL_W'(g) &&
                        rd_addr[(g*NRD+p)*AW +: QSEL_W] == QSEL_W'(d))
                        served[d][g*(NRD+1)+p] = 1'b1;
                end
                if (wr_en[g] && !wr_stall[g] &&
                    wr_addr[g*AW +: QSEL_W] != QSEL_W'(g) &&
                    wr_addr[g*AW +: QSEL_W] == QSEL_W'(d))
                    served[d][g*(NRD+1)+NRD] = 1'b1;
            end
        end
    end

    for (genvar d = 0; d < NG; d++) begin : g_d
        p_one_per_dest_r4: assert property (@(posedge clk) disable iff (rst)
            $countones(served[d]) <= 1);
    end

    for (genvar g = 0; g < NG; g++) begin : g_g
        p_wr_local_go_r2: assert property (@(posedge clk) disable iff (rst)
            (wr_en[g] && wr_addr[g*AW +: QSEL_W] == QSEL_W'(g)) |-> !wr_stall[g]);

        p_wr_stall_en_r4: assert property (@(posedge clk) disable iff (rst)
            wr_stall[g] |-> wr_en[g]);

        for (genvar p = 0; p < NRD; p++) begin : g_p
            localparam int RI = g * NRD + p;

            logic [CW-1:0]     wait_cnt;
            logic [AW-1:0]     prev_addr;

            // consecutive stalled cycles of one unchanged request
            always_ff @(posedge clk) begin
                if (rst) begin
                    wait_cnt  <= '0;
                    prev_addr <= '0;
                end else begin
                    prev_addr <= rd_addr[RI*AW +: AW];
                    if (rd_stall[RI] &&
                        (wait_cnt == '0 || prev_addr == rd_addr[RI*AW +: AW]))
                        wait_cnt <= wait_cnt + 1'b1;
                    else if (rd_stall[RI])
                        wait_cnt <= CW'(1);
                    else
                        wait_cnt <= '0;
                end
            end

            p_rd_local_go_r2: assert property (@(posedge clk) disable iff (rst)
                (rd_en[RI] && rd_addr[RI*AW +: QSEL_W] == QSEL_W'(g)) |-> !rd_stall[RI]);

            p_rd_stall_en_r4: assert property (@(posedge clk) disable iff (rst)
                rd_stall[RI] |-> rd_en[RI]);

            p_vld_served_r10: assert property (@(posedge clk) disable iff (rst)
                (rd_en[RI] && !rd_stall[RI]) |=> rd_vld[RI]);

            p_vld_idle_r10: assert property (@(posedge clk) disable iff (rst)
                !(rd_en[RI] && !rd_stall[RI]) |=> !rd_vld[RI]);

            p_hold_data_r10: assert property (@(posedge clk) disable iff (rst)
                !rd_vld[RI] |-> $stable(rd_data[RI*DW +: DW]));

            p_wait_bound_r5: assert property (@(posedge clk) disable iff (rst)
                wait_cnt < CW'(NREQ));
        end
    end

endmodule

bind qbank_regfile qbr_checker #(.DW(DW), .QDEPTH(QDEPTH), .NRD(NRD)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_stall (rd_stall),
    .rd_vld   (rd_vld),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_stall (wr_stall)
);

// File: tb/sim_qbank_regfile.sv
`timescale 1ns/1ps
module sim_qbank_regfile;

    localparam int DW    = 32;
    localparam int QD    = 8;
    localparam int NRD   = 3;
    localparam int NG    = 4;
    localparam int IW    = 3;
    localparam int AW    = 5;
    localparam int NRP   = NG * NRD;
    localparam int NPORT = NRD + 1;
    localparam int NREQ  = NG * NPORT;
    localparam int NREG  = NG * QD;

    logic              clk = 1'b0;
    logic              rst;
    logic [NRP-1:0]    rd_en;
    logic [NRP*AW-1:0] rd_addr;
    logic [NRP-1:0]    rd_stall;
    logic [NRP-1:0]    rd_vld;
    logic [NRP*DW-1:0] rd_data;
    logic [NG-1:0]     wr_en;
    logic [NG*AW-1:0]  wr_addr;
    logic [NG*DW-1:0]  wr_data;
    logic [NG-1:0]     wr_stall;

    always #5 clk = ~clk;

    qbank_regfile #(.DW(DW), .QDEPTH(QD), .NRD(NRD)) u0 (
        .clk(clk), .rst(rst),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_stall(rd_stall),
        .rd_vld(rd_vld), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_stall(wr_stall)
    );

    // stimulus
    logic          b_ren   [NRP];
    logic [AW-1:0] b_raddr [NRP];
    logic          b_wen   [NG];
    logic [AW-1:0] b_waddr [NG];
    logic [DW-1:0] b_wdata [NG];

    always_comb begin
        for (int i = 0; i < NRP; i++) begin
            rd_en[i]             = b_ren[i];
            rd_addr[i*AW +: AW]  = b_raddr[i];
        end
        for (int g = 0; g < NG; g++) begin
            wr_en[g]             = b_wen[g];
            wr_addr[g*AW +: AW]  = b_waddr[g];
            wr_data[g*DW +: DW]  = b_wdata[g];
        end
    end

    // reference state
    logic [DW-1:0] m_mem  [NREG];
    int            m_ptr  [NG];
    logic          e_vld  [NRP];
    logic [DW-1:0] e_dat  [NRP];

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear_stim();
        for (int i = 0; i < NRP; i++) begin b_ren[i] = 0; b_raddr[i] = '0; end
        for (int g = 0; g < NG; g++) begin b_wen[g] = 0; b_waddr[g] = '0; b_wdata[g] = '0; end
    endtask

    function automatic int qof(input logic [AW-1:0] a);
        return int'(a[1:0]);
    endfunction

    // one clock of stimulus: called just after a falling edge with stimulus set
    task automatic step(input string tag);
        logic          en   [NREQ];
        int            dst  [NREQ];
        logic          gnt  [NREQ];
        logic          rstl [NRP];
        logic          wstl [NG];
        #1;
        for (int g = 0; g < NG; g++) begin
            for (int p = 0; p < NPORT; p++) begin
                int id;
                id = g*NPORT + p;
                gnt[id] = 0;
                if (p < NRD) begin
                    dst[id] = qof(b_raddr[g*NRD+p]);
                    en[id]  = b_ren[g*NRD+p] && dst[id] != g;
                end else begin
                    dst[id] = qof(b_waddr[g]);
                    en[id]  = b_wen[g] && dst[id] != g;
                end
            end
        end
        // rotating priority per destination quadrant
        for (int d = 0; d < NG; d++) begin
            for (int i = 0; i < NREQ; i++) begin
                int j;
                j = (m_ptr[d] + i) % NREQ;
                if (en[j] && dst[j] == d) begin
                    gnt[j]   = 1;
                    m_ptr[d] = (j + 1) % NREQ;
                    break;
                end
            end
        end
        for (int g = 0; g < NG; g++) begin
            for (int p = 0; p < NRD; p++) begin
                int ri;
                ri = g*NRD + p;
                rstl[ri] = en[g*NPORT+p] && !gnt[g*NPORT+p];
                chk(tag, $sformatf("rd_stall[%0d]", ri), DW'(rd_stall[ri]), DW'(rstl[ri]));
                if (b_ren[ri] && !rstl[ri]) begin
                    e_vld[ri] = 1;
                    e_dat[ri] = m_mem[b_raddr[ri]];
                end else begin
                    e_vld[ri] = 0;
                end
            end
            wstl[g] = en[g*NPORT+NRD] && !gnt[g*NPORT+NRD];
            chk(tag, $sformatf("wr_stall[%0d]", g), DW'(wr_stall[g]), DW'(wstl[g]));
        end
        // crossbar writes first, then local writes override
        for (int g = 0; g < NG; g++)
            if (b_wen[g] && qof(b_waddr[g]) != g && !wstl[g]) m_mem[b_waddr[g]] = b_wdata[g];
        for (int g = 0; g < NG; g++)
            if (b_wen[g] && qof(b_waddr[g]) == g) m_mem[b_waddr[g]] = b_wdata[g];
        @(posedge clk);
        #2;
        for (int ri = 0; ri < NRP; ri++) begin
            chk(tag, $sformatf("rd_vld[%0d]", ri), DW'(rd_vld[ri]), DW'(e_vld[ri]));
            chk(tag, $sformatf("rd_data[%0d]", ri), rd_data[ri*DW +: DW], e_dat[ri]);
        end
        @(negedge clk);
    endtask

    task automatic rd(input int g, input int p, input int a);
        b_ren[g*NRD+p] = 1; b_raddr[g*NRD+p] = AW'(a);
    endtask

    task automatic wr(input int g, input int a, input logic [DW-1:0] v);
        b_wen[g] = 1; b_waddr[g] = AW'(a); b_wdata[g] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        clear_stim();
        for (int k = 0; k < NREG; k++) m_mem[k] = '0;
        for (int d = 0; d < NG; d++) m_ptr[d] = 0;
        for (int i = 0; i < NRP; i++) begin e_vld[i] = 0; e_dat[i] = '0; end
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R11: reset state at the ports
        for (int i = 0; i < NRP; i++) begin
            chk("R11", "rd_vld after reset", DW'(rd_vld[i]), '0);
            chk("R11", "rd_data after reset", rd_data[i*DW +: DW], '0);
            chk("R11", "rd_stall idle", DW'(rd_stall[i]), '0);
        end
        // R11: every register reads zero (local reads, one quadrant per group)
        for (int k = 0; k < QD; k++) begin
            clear_stim();
            for (int g = 0; g < NG; g++) rd(g, 0, k*4 + g);
            step("R11");
        end

        // R1: register 5 belongs to quadrant 1, index 1; group 1 local, group 0 remote
        clear_stim(); wr(1, 5, 32'h0000_5A5A); step("R1");
        clear_stim(); rd(1, 0, 5); rd(0, 1, 5); step("R1");

        // R3: four groups write their own quadrant, then all ports read locally
        clear_stim();
        for (int g = 0; g < NG; g++) wr(g, 8 + g, 32'hA000_0000 + g);
        step("R3");
        clear_stim();
        for (int g = 0; g < NG; g++)
            for (int p = 0; p < NRD; p++) rd(g, p, 4*p + 8 + g);
        step("R3");

        // R4: three groups read quadrant 0 at once, only one served
        clear_stim(); rd(1, 0, 0); rd(2, 0, 4); rd(3, 0, 8); step("R4");

        // R5: every non-local port hammers quadrant 0 for a long stretch
        clear_stim();
        for (int g = 1; g < NG; g++) begin
            for (int p = 0; p < NRD; p++) rd(g, p, 4*p);
            wr(g, 4*g, 32'hC0DE_0000 + g);
        end
        repeat (16) step("R5");

        // R6: crossbar read of a value written before
        clear_stim(); wr(2, 14, 32'h1234_5678); step("R6");
        clear_stim(); rd(3, 2, 14); step("R6");

        // R7: crossbar write then crossbar read next cycle
        clear_stim(); wr(0, 7, 32'hBEEF_0007); step("R7");
        clear_stim(); rd(2, 1, 7); step("R7");

        // R8: local and crossbar write hit register 4 together
        clear_stim(); wr(0, 4, 32'h1111_1111); wr(1, 4, 32'h2222_2222); step("R8");
        clear_stim(); rd(0, 0, 4); step("R8");

        // R9: read and write same register in one cycle, local and crossbar
        clear_stim(); wr(3, 11, 32'h0B0B_0B0B); step("R9");
        clear_stim(); rd(3, 0, 11); rd(1, 1, 11); wr(3, 11, 32'h0C0C_0C0C); step("R9");
        clear_stim(); rd(3, 0, 11); step("R9");

        // R10: idle cycles keep the last read data
        clear_stim(); step("R10"); step("R10");

        // R2 and mixed traffic: random over a small address window
        for (int n = 0; n < 4000; n++) begin
            clear_stim();
            for (int i = 0; i < NRP; i++)
                if ($urandom_range(0, 2) != 0) begin
                    b_ren[i] = 1; b_raddr[i] = AW'($urandom_range(0, 11));
                end
            for (int g = 0; g < NG; g++)
                if ($urandom_range(0, 1) != 0) wr(g, $urandom_range(0, 11), $urandom());
            step("R2");
        end

        clear_stim(); step("R10");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule